// File: doc/BRIEF.md
# Scan-to-Processor Debug Mailbox

This block lets a debugger on a scan port and a program on the processor pass 32-bit words to each other. It holds an inbound word (written by the scan side, read by the processor), an outbound word (written by the processor, read by the scan side) and a small handshake register with a full flag for each direction and a keep-awake bit. The scan side sees each of these as a data chain between `tdi` and `tdo`. Two further chains put a full flag directly in front of its data word, so that a flag and its word move in a single 33-bit scan.

The scan logic runs on `tck` and is driven by already decoded capture, shift and update strobes and by a chain select code. The TAP state machine and the instruction register live outside this block. Each update is carried into the system clock domain by a toggle synchronizer. The processor reaches the three registers through a plain write-enable/address/data port. A scan-side request to mark the inbound word full produces a one-cycle interrupt pulse on the system clock.

Top module: `dbg_mailbox`

## Requirements
- R1: After reset the inbound full flag and the outbound full flag are 0, the keep-awake bit is 1 (the handshake register reads 0x04), `irq` is low and both data words are 0.
- R2: The processor reads and writes the inbound word at offset 0x0, the outbound word at offset 0x4 and the handshake register at offset 0x8. Any other offset reads 0, and a write to it changes nothing.
- R3: Handshake register layout: bit 0 is the inbound full flag, bit 1 the outbound full flag, bit 2 the keep-awake bit. Bits 7:3 always read 0 and writes to them are ignored. A processor write loads bits 2:0 directly and raises no interrupt.
- R4: `chain_sel` picks the chain: 1 is the inbound word (32 bits), 2 the outbound word (32), 3 the handshake register (8), 4 the inbound flag plus the inbound word (33), 5 the outbound flag plus the outbound word (33). Any other code leaves `tdo` at 0 and makes capture, shift and update have no effect.
- R5: Capture loads the current register values into the chain. Bits leave on `tdo` starting from bit 0, and `tdi` enters at the top bit. In the combined chains the flag is bit 0, so it shifts out first, and the data word sits in bits 32:1.
- R6: An update of chain 1 or chain 4 loads the shifted-in word into the inbound register.
- R7: The outbound word is read-only from the scan side. An update of chain 2 or chain 5 never changes it, and repeated scans return the same value.
- R8: From the scan side (chain 3 bit 1, chain 5 bit 0), writing 1 to the outbound full flag clears it and writing 0 leaves it unchanged.
- R9: From the scan side (chain 3 bit 0, chain 4 bit 0), writing 1 to the inbound full flag sets it and raises an interrupt. Writing 0 leaves it unchanged and raises no interrupt.
- R10: An update of chain 3 loads bit 2 into the keep-awake bit.
- R11: An update takes effect in the system domain within 6 system clock cycles after the `tck` edge that samples `update_dr`.
- R12: Each scan-side write of 1 to the inbound full flag gives exactly one `irq` pulse, one system clock wide, and the flag reads 1 while the pulse is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sys_clk | input | 1 | System clock |
| sys_rst_n | input | 1 | System domain reset, active low |
| reg_addr | input | 4 | Processor register byte offset |
| reg_wen | input | 1 | Processor write strobe |
| reg_wdata | input | 32 | Processor write data |
| reg_rdata | output | 32 | Processor read data for `reg_addr` |
| irq | output | 1 | Inbound-full interrupt pulse |
| tck | input | 1 | Scan clock |
| tck_rst_n | input | 1 | Scan domain reset, active low |
| tdi | input | 1 | Scan data in |
| chain_sel | input | 3 | Active chain code from the instruction decode |
| capture_dr | input | 1 | Capture strobe, sampled on `tck` rising edge |
| shift_dr | input | 1 | Shift strobe, sampled on `tck` rising edge |
| update_dr | input | 1 | Update strobe, sampled on `tck` rising edge |
| tdo | output | 1 | Scan data out |

## Verification
The bench writes 0 and then 1 into each flag from the scan side. A design that swapped keep and clear would set the outbound flag where it should clear it, or raise an interrupt on a 0. It scans the outbound word repeatedly while shifting ones into it; a design that let updates through, or that captured destructively, would return changed data. The combined chains are checked with a known flag and word, so a design that placed the flag at the far end or shifted MSB first shows a rotated result. Unused handshake bits, unmapped offsets and unassigned chain codes are driven with all ones. A design that decoded them loosely would show a nonzero read or an altered register.

// File: rtl/dbg_mbx_pkg.sv
package dbg_mbx_pkg;

    typedef enum logic [2:0] {
        CH_NONE     = 3'd0,
        CH_IN       = 3'd1,
        CH_OUT      = 3'd2,
        CH_CTRL     = 3'd3,
        CH_IN_FLAG  = 3'd4,
        CH_OUT_FLAG = 3'd5
    } chain_e;

    localparam int FLAG_IN_BIT  = 0;
    localparam int FLAG_OUT_BIT = 1;
    localparam int AWAKE_BIT    = 2;

    localparam int OFS_IN   = 0;
    localparam int OFS_OUT  = 4;
    localparam int OFS_CTRL = 8;

    function automatic logic chain_valid(input logic [2:0] code);
        return (code >= 3'd1) && (code <= 3'd5);
    endfunction

endpackage

// File: rtl/dbg_mbx_scan.sv
module dbg_mbx_scan
    import dbg_mbx_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int CTRL_W = 8,
    localparam int SR_W  = DATA_W + 1
) (
    input  logic              tck,
    input  logic              rst_n,
    input  logic              tdi,
    input  logic [2:0]        sel,
    input  logic              capture,
    input  logic              shift,
    input  logic              update,
    input  logic [DATA_W-1:0] cap_in,
    input  logic [DATA_W-1:0] cap_out,
    input  logic [CTRL_W-1:0] cap_ctrl,
    input  logic              cap_in_flag,
    input  logic              cap_out_flag,
    output logic              tdo,
    output logic [SR_W-1:0]   hold_data,
    output chain_e            hold_sel,
    output logic              hold_tgl
);

    typedef struct packed {
        logic [SR_W-1:0] sr;
        logic [SR_W-1:0] hold;
        chain_e          hsel;
        logic            tgl;
    } scan_t;

    scan_t st_d, st_q;
    logic  active;
    chain_e sel_e;

    always_comb begin
        sel_e  = chain_e'(sel);
        active = chain_valid(sel);
        st_d   = st_q;
        if (active && capture) begin
            st_d.sr = '0;
            unique case (sel_e)
                CH_IN:       st_d.sr[DATA_W-1:0] = cap_in;
                CH_OUT:      st_d.sr[DATA_W-1:0] = cap_out;
                CH_CTRL:     st_d.sr[CTRL_W-1:0] = cap_ctrl;
                CH_IN_FLAG:  st_d.sr = {cap_in, cap_in_flag};
                CH_OUT_FLAG: st_d.sr = {cap_out, cap_out_flag};
                default:     st_d.sr = '0;
            endcase
        end else if (active && shift) begin
            st_d.sr = st_q.sr >> 1;
            unique case (sel_e)
                CH_IN, CH_OUT:           st_d.sr[DATA_W-1] = tdi;
                CH_CTRL:                 st_d.sr[CTRL_W-1] = tdi;
                CH_IN_FLAG, CH_OUT_FLAG: st_d.sr[SR_W-1]   = tdi;
                default:                 st_d.sr = st_q.sr;
            endcase
        end else if (active && update) begin
            st_d.hold = st_q.sr;
            st_d.hsel = sel_e;
            st_d.tgl  = ~st_q.tgl;
        end
    end

    always_ff @(posedge tck or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{sr: '0, hold: '0, hsel: CH_NONE, tgl: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign tdo       = active ? st_q.sr[0] : 1'b0;
    assign hold_data = st_q.hold;
    assign hold_sel  = st_q.hsel;
    assign hold_tgl  = st_q.tgl;

    // R4: an unassigned chain code keeps the update toggle still
    a_r4_idle_no_update: assert property (@(posedge tck) disable iff (!rst_n)
        (!chain_valid(sel) && update) |=> $stable(hold_tgl));

    // R11: every valid update edge flips the toggle seen by the system side
    a_r11_update_toggles: assert property (@(posedge tck) disable iff (!rst_n)
        (chain_valid(sel) && update && !capture && !shift) |=> (hold_tgl != $past(hold_tgl)));

endmodule

// File: rtl/dbg_mbx_sync.sv
module dbg_mbx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tgl_in,
    output logic pulse
);

    typedef struct packed {
        logic [STAGES-1:0] chain;
        logic              last;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.chain = {st_q.chain[STAGES-2:0], tgl_in};
        st_d.last  = st_q.chain[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pulse = st_q.chain[STAGES-1] ^ st_q.last;

    // R11: one toggle yields one system-clock event
    a_r11_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
        pulse |=> !pulse);

endmodule

// File: rtl/dbg_mbx_regs.sv
module dbg_mbx_regs
    import dbg_mbx_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int CTRL_W = 8,
    parameter int ADDR_W = 4,
    localparam int SR_W  = DATA_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wen,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic              upd_pulse,
    input  logic [SR_W-1:0]   upd_data,
    input  chain_e            upd_sel,
    output logic [DATA_W-1:0] in_word,
    output logic [DATA_W-1:0] out_word,
    output logic [CTRL_W-1:0] ctrl_byte,
    output logic              in_full,
    output logic              out_full,
    output logic              irq
);

    localparam logic [ADDR_W-1:0] A_IN   = ADDR_W'(OFS_IN);
    localparam logic [ADDR_W-1:0] A_OUT  = ADDR_W'(OFS_OUT);
    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFS_CTRL);

    typedef struct packed {
        logic [DATA_W-1:0] din;
        logic [DATA_W-1:0] dout;
        logic              ifull;
        logic              ofull;
        logic              awake;
        logic              irq;
    } regs_t;

    regs_t st_d, st_q;
    logic  cpu_ctrl_wr;
    logic  cpu_out_wr;

    always_comb begin
        st_d        = st_q;
        st_d.irq    = 1'b0;
        cpu_ctrl_wr = wen && (addr == A_CTRL);
        cpu_out_wr  = wen && (addr == A_OUT);
        if (wen && addr == A_IN)  st_d.din  = wdata;
        if (cpu_out_wr)           st_d.dout = wdata;
        if (cpu_ctrl_wr) begin
            st_d.ifull = wdata[FLAG_IN_BIT];
            st_d.ofull = wdata[FLAG_OUT_BIT];
            st_d.awake = wdata[AWAKE_BIT];
        end
        if (upd_pulse) begin
            unique case (upd_sel)
                CH_IN: st_d.din = upd_data[DATA_W-1:0];
                CH_CTRL: begin
                    if (upd_data[FLAG_IN_BIT]) begin
                        st_d.ifull = 1'b1;
                        st_d.irq   = 1'b1;
                    end
                    if (upd_data[FLAG_OUT_BIT]) st_d.ofull = 1'b0;
                    st_d.awake = upd_data[AWAKE_BIT];
                end
                CH_IN_FLAG: begin
                    st_d.din = upd_data[SR_W-1:1];
                    if (upd_data[0]) begin
                        st_d.ifull = 1'b1;
                        st_d.irq   = 1'b1;
                    end
                end
                CH_OUT_FLAG: if (upd_data[0]) st_d.ofull = 1'b0;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{din: '0, dout: '0, ifull: 1'b0, ofull: 1'b0, awake: 1'b1, irq: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        ctrl_byte               = '0;
        ctrl_byte[FLAG_IN_BIT]  = st_q.ifull;
        ctrl_byte[FLAG_OUT_BIT] = st_q.ofull;
        ctrl_byte[AWAKE_BIT]    = st_q.awake;
        unique case (addr)
            A_IN:    rdata = st_q.din;
            A_OUT:   rdata = st_q.dout;
            A_CTRL:  rdata = DATA_W'(ctrl_byte);
            default: rdata = '0;
        endcase
    end

    assign in_word  = st_q.din;
    assign out_word = st_q.dout;
    assign in_full  = st_q.ifull;
    assign out_full = st_q.ofull;
    assign irq      = st_q.irq;

    // R12: interrupt is one cycle wide
    a_r12_irq_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);

    // R12: the inbound flag is already set while the interrupt is high
    a_r12_irq_with_flag: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> in_full);

    // R7: scan-side updates never alter the outbound word
    a_r7_out_readonly: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_pulse && !cpu_out_wr) |=> $stable(out_word));

    // R8: a scan-side one on the outbound flag leaves it clear
    a_r8_ofull_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_pulse && upd_sel == CH_OUT_FLAG && upd_data[0] && !cpu_ctrl_wr) |=> !out_full);

    // R9: a scan-side zero on the inbound flag changes nothing and raises nothing
    a_r9_ifull_keep: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_pulse && upd_sel == CH_CTRL && !upd_data[FLAG_IN_BIT] && !cpu_ctrl_wr)
        |=> ($stable(in_full) && !irq));

endmodule

// File: rtl/dbg_mailbox.sv
module dbg_mailbox
    import dbg_mbx_pkg::*;
#(
    parameter int DATA_W      = 32,
    parameter int CTRL_W      = 8,
    parameter int ADDR_W      = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic              sys_clk,
    input  logic              sys_rst_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wen,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq,
    input  logic              tck,
    input  logic              tck_rst_n,
    input  logic              tdi,
    input  logic [2:0]        chain_sel,
    input  logic              capture_dr,
    input  logic              shift_dr,
    input  logic              update_dr,
    output logic              tdo
);

    localparam int SR_W = DATA_W + 1;

    logic [SR_W-1:0]   hold_data;
    chain_e            hold_sel;
    logic              hold_tgl;
    logic              upd_pulse;
    logic [DATA_W-1:0] in_word;
    logic [DATA_W-1:0] out_word;
    logic [CTRL_W-1:0] ctrl_byte;
    logic              in_full;
    logic              out_full;

    dbg_mbx_scan #(.DATA_W(DATA_W), .CTRL_W(CTRL_W)) u_scan (
        .tck          (tck),
        .rst_n        (tck_rst_n),
        .tdi          (tdi),
        .sel          (chain_sel),
        .capture      (capture_dr),
        .shift        (shift_dr),
        .update       (update_dr),
        .cap_in       (in_word),
        .cap_out      (out_word),
        .cap_ctrl     (ctrl_byte),
        .cap_in_flag  (in_full),
        .cap_out_flag (out_full),
        .tdo          (tdo),
        .hold_data    (hold_data),
        .hold_sel     (hold_sel),
        .hold_tgl     (hold_tgl)
    );

    dbg_mbx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (sys_clk),
        .rst_n  (sys_rst_n),
        .tgl_in (hold_tgl),
        .pulse  (upd_pulse)
    );

    dbg_mbx_regs #(.DATA_W(DATA_W), .CTRL_W(CTRL_W), .ADDR_W(ADDR_W)) u_regs (
        .clk       (sys_clk),
        .rst_n     (sys_rst_n),
        .addr      (reg_addr),
        .wen       (reg_wen),
        .wdata     (reg_wdata),
        .rdata     (reg_rdata),
        .upd_pulse (upd_pulse),
        .upd_data  (hold_data),
        .upd_sel   (hold_sel),
        .in_word   (in_word),
        .out_word  (out_word),
        .ctrl_byte (ctrl_byte),
        .in_full   (in_full),
        .out_full  (out_full),
        .irq       (irq)
    );

endmodule

// File: tb/test_dbg_mailbox.sv
`timescale 1ns/1ps
module test_dbg_mailbox;

    logic        sys_clk = 1'b0;
    logic        sys_rst_n = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic        reg_wen = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq;
    logic        tck = 1'b0;
    logic        tck_rst_n = 1'b0;
    logic        tdi = 1'b0;
    logic [2:0]  chain_sel = '0;
    logic        capture_dr = 1'b0;
    logic        shift_dr = 1'b0;
    logic        update_dr = 1'b0;
    logic        tdo;

    int n_cmp = 0;
    int n_bad = 0;
    int irq_rises = 0;
    int irq_high = 0;
    logic irq_prev = 1'b0;
    bit done = 1'b0;

    typedef struct {
        string       tag;
        logic [32:0] val;
    } item_t;
    item_t exp_q[$];
    logic [32:0] act_q[$];

    always #2.5 sys_clk = ~sys_clk;

    dbg_mailbox i_dbg_mailbox (
        .sys_clk(sys_clk), .sys_rst_n(sys_rst_n), .reg_addr(reg_addr),
        .reg_wen(reg_wen), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq(irq), .tck(tck), .tck_rst_n(tck_rst_n), .tdi(tdi),
        .chain_sel(chain_sel), .capture_dr(capture_dr), .shift_dr(shift_dr),
        .update_dr(update_dr), .tdo(tdo)
    );

    always @(negedge sys_clk) begin
        if (sys_rst_n) begin
            if (irq) irq_high++;
            if (irq && !irq_prev) irq_rises++;
            irq_prev <= irq;
        end
    end

    // scoreboard monitor
    initial begin
        forever begin
            wait (exp_q.size() > 0 && act_q.size() > 0);
            begin
                item_t e;
                logic [32:0] a;
                e = exp_q.pop_front();
                a = act_q.pop_front();
                n_cmp++;
                if (a !== e.val) begin
                    n_bad++;
                    $display("FAIL %s: actual 0x%0h expected 0x%0h", e.tag, a, e.val);
                end
            end
        end
    end

    task automatic expect_val(input string tag, input logic [32:0] v);
        exp_q.push_back('{tag: tag, val: v});
    endtask

    task automatic sys_wait(input int n);
        for (int i = 0; i < n; i++) @(negedge sys_clk);
    endtask

    task automatic cpu_write(input logic [3:0] a, input logic [31:0] d);
        @(negedge sys_clk);
        reg_addr  = a;
        reg_wdata = d;
        reg_wen   = 1'b1;
        @(negedge sys_clk);
        reg_wen   = 1'b0;
    endtask

    task automatic cpu_check(input string tag, input logic [3:0] a, input logic [31:0] e);
        @(negedge sys_clk);
        reg_addr = a;
        #1;
        expect_val(tag, {1'b0, e});
        act_q.push_back({1'b0, reg_rdata});
    endtask

    task automatic tck_pulse;
        #10 tck = 1'b1;
        #20 tck = 1'b0;
        #10;
    endtask

    task automatic scan(input logic [2:0] sel, input int n, input logic [32:0] din,
                        output logic [32:0] cap);
        cap = '0;
        chain_sel  = sel;
        capture_dr = 1'b1;
        tck_pulse();
        capture_dr = 1'b0;
        shift_dr   = 1'b1;
        for (int i = 0; i < n; i++) begin
            tdi    = din[i];
            #1;
            cap[i] = tdo;
            tck_pulse();
        end
        shift_dr  = 1'b0;
        update_dr = 1'b1;
        tck_pulse();
        update_dr = 1'b0;
        chain_sel = 3'd0;
        sys_wait(6);
    endtask

    task automatic scan_check(input string tag, input logic [2:0] sel, input int n,
                              input logic [32:0] din, input logic [32:0] e);
        logic [32:0] c;
        expect_val(tag, e);
        scan(sel, n, din, c);
        act_q.push_back(c);
    endtask

    task automatic count_check(input string tag, input int act, input int e);
        expect_val(tag, 33'(e));
        act_q.push_back(33'(act));
    endtask

    initial begin
        #500000;
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        sys_wait(4);
        sys_rst_n = 1'b1;
        tck_rst_n = 1'b1;
        sys_wait(2);

        // R1 reset state
        cpu_check("R1 ctrl after reset", 4'h8, 32'h04);
        cpu_check("R1 inbound after reset", 4'h0, 32'h0);
        count_check("R1 irq low after reset", int'(irq), 0);
        count_check("R4 tdo idle", int'(tdo), 0);

        // R2/R3 processor access
        cpu_write(4'h4, 32'hA5A5_1234);
        cpu_write(4'h8, 32'h06);
        cpu_check("R3 ctrl write", 4'h8, 32'h06);
        cpu_check("R2 outbound read", 4'h4, 32'hA5A5_1234);

        // R5/R8 combined outbound chain, flag first
        scan_check("R5 out+flag capture", 3'd5, 33, 33'h0, {32'hA5A5_1234, 1'b1});
        cpu_check("R8 ofull keeps on 0", 4'h8, 32'h06);
        scan_check("R5 out+flag capture again", 3'd5, 33, 33'h1, {32'hA5A5_1234, 1'b1});
        cpu_check("R8 ofull cleared on 1", 4'h8, 32'h04);
        cpu_check("R7 outbound kept after chain 5", 4'h4, 32'hA5A5_1234);

        // R7 outbound read-only chain
        scan_check("R7 out capture", 3'd2, 32, 33'h0_FFFF_FFFF, {1'b0, 32'hA5A5_1234});
        scan_check("R7 out nondestructive", 3'd2, 32, 33'h0_FFFF_FFFF, {1'b0, 32'hA5A5_1234});
        cpu_check("R7 outbound unchanged", 4'h4, 32'hA5A5_1234);

        // R6/R11 inbound chain (read 6 cycles after update)
        scan_check("R6 in capture", 3'd1, 32, {1'b0, 32'hDEAD_BEEF}, 33'h0);
        cpu_check("R11 R6 inbound written", 4'h0, 32'hDEAD_BEEF);
        cpu_check("R9 no flag from chain 1", 4'h8, 32'h04);
        count_check("R9 no irq from chain 1", irq_rises, 0);

        // R9/R12 combined inbound chain
        scan_check("R5 in+flag capture", 3'd4, 33, {32'h1234_5678, 1'b1}, {32'hDEAD_BEEF, 1'b0});
        cpu_check("R6 inbound from chain 4", 4'h0, 32'h1234_5678);
        cpu_check("R9 ifull set", 4'h8, 32'h05);
        count_check("R12 one irq pulse", irq_rises, 1);
        count_check("R12 irq one cycle wide", irq_high, 1);

        // R9/R10 handshake chain
        cpu_write(4'h8, 32'h04);
        scan_check("R5 ctrl capture", 3'd3, 8, 33'h04, 33'h04);
        cpu_check("R9 ifull keeps on 0", 4'h8, 32'h04);
        count_check("R9 no irq on 0", irq_rises, 1);
        scan_check("R5 ctrl capture 2", 3'd3, 8, 33'h01, 33'h04);
        cpu_check("R10 R9 ifull set awake cleared", 4'h8, 32'h01);
        count_check("R12 second irq", irq_rises, 2);
        scan_check("R5 ctrl capture 3", 3'd3, 8, 33'h06, 33'h01);
        cpu_check("R10 awake set ofull stays clear", 4'h8, 32'h05);

        // R3 unused bits
        cpu_write(4'h8, 32'hF8);
        cpu_check("R3 unused bits ignored", 4'h8, 32'h00);
        cpu_write(4'h8, 32'hFFFF_FFFF);
        cpu_check("R3 unused bits read 0", 4'h8, 32'h07);

        // R2 unmapped offset
        cpu_write(4'hC, 32'hFFFF_FFFF);
        cpu_check("R2 unmapped reads 0", 4'hC, 32'h0);
        cpu_check("R2 inbound untouched", 4'h0, 32'h1234_5678);

        // R4 unassigned chain codes
        scan_check("R4 code 0 tdo 0", 3'd0, 8, 33'hFF, 33'h0);
        scan_check("R4 code 6 tdo 0", 3'd6, 33, 33'h1_FFFF_FFFF, 33'h0);
        cpu_check("R4 ctrl untouched", 4'h8, 32'h07);
        cpu_check("R4 inbound untouched", 4'h0, 32'h1234_5678);
        count_check("R12 total irq cycles", irq_high, 2);

        wait (exp_q.size() == 0 && act_q.size() == 0);
        #1;
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule